// File: doc/BRIEF.md
# Burst SRAM Front End

This block is the clocked control side of a single-port, byte-writable burst SRAM. On every rising clock edge it samples three chip enables, two active-low address strobes, an advance strobe, a global write enable, a byte-write enable and four byte selects. From these it decides whether to load a new address, drop out of selection or continue the current burst. It holds the captured address in a register. The two lowest bits of that address form a wrapping burst counter. A small behavioural storage array sits inside the block.

Writes happen only in burst-continuation cycles, at the address the block currently holds. Reads are pipelined. The word at the held address is copied into an output register on the next edge, and it reaches the data output only while the asynchronous output enable is low. Pad three-stating is modelled by the `dq_oe` output, and the data output is forced to zero whenever `dq_oe` is low.

There is no valid/ready handshake on either data path. A selected, non-writing edge always produces one read word, and the consumer cannot stall it. Write data is taken in the cycle it is presented.

Top module: `sram_burst_front`

## Requirements
- R1: A recognised strobe, sampled while `ce1_n`=0, `ce2`=1 and `ce3_n`=0, loads `addr` into the address register. `burst_addr` shows the loaded value after that edge, and the block becomes selected.
- R2: A recognised strobe sampled with any chip enable inactive deselects the block. `burst_addr` holds its value, no lane write strobe is raised in that cycle, and no data is driven after the following edge.
- R3: The processor strobe `adsp_n` is ignored while `ce1_n` is 1. If the controller strobe is idle in that cycle, the cycle behaves as a plain continuation cycle.
- R4: When `adsp_n` and `adsc_n` are both low, the processor strobe is acted on. Write enables are then ignored in that cycle, so `lane_we` is 0000. If `ce1_n` is 1 in that cycle, the controller strobe is acted on instead.
- R5: A cycle is a continuation cycle when the block is selected and no strobe is recognised. Only continuation cycles can write, and they write to the word at `burst_addr`.
- R6: In a continuation cycle with `adv_n`=0, `burst_addr[1:0]` increments modulo 4 at the edge, and `burst_addr[17:2]` stays unchanged.
- R7: With `adv_n`=1 and no recognised strobe, `burst_addr` holds. While the block is deselected, `adv_n` has no effect.
- R8: In a continuation cycle with `gw_n`=0, `lane_we` is 1111 whatever `bwe_n` and `bw_n` are. Lane bit k writes `wdata[8k+7:8k]`.
- R9: In a continuation cycle with `gw_n`=1 and `bwe_n`=0, `lane_we[k]` equals the inverse of `bw_n[k]`. With `bwe_n`=1, `lane_we` is 0000.
- R10: A selected edge without a write reads the word at the `burst_addr` held before that edge. After the edge, `rdata` shows that word and `dq_oe` is 1 while `oe_n`=0.
- R11: `oe_n`=1 forces `dq_oe` to 0 and `rdata` to zero at once, without waiting for a clock edge.
- R12: After an edge that selects the block from the deselected state, `dq_oe` stays 0 for one cycle even with `oe_n`=0. The same holds after every write edge.
- R13: Reset leaves the block deselected, with `burst_addr` at 0, `dq_oe` at 0 and `lane_we` at 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| addr | input | 18 | Address presented with a strobe |
| adsp_n | input | 1 | Processor address strobe, active low, masked by `ce1_n` |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low, writes all four lanes |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | 4 | Per-lane byte selects, active low |
| wdata | input | 32 | Write data, lane k in bits [8k+7:8k] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_addr | output | 18 | Address the block currently holds |
| lane_we | output | 4 | Lane write strobes for the current cycle |
| dq_oe | output | 1 | Output-driver enable |
| rdata | output | 32 | Read data, zero while not driven |

## Verification
On every cycle the assertions check the following:
- address loading on a qualified strobe;
- chip-enable-1 masking of the processor strobe;
- strobe priority as seen on the lane strobes;
- counter stepping and holding;
- the global-write override;
- the combinational output-enable gate;
- suppression of driving after a selection that starts from idle.

Only the bench scenarios show the following:
- that data written in byte lanes comes back merged in later reads;
- that read words arrive one edge late through the wrap from 3 back to 0;
- that a deselected advance or a masked global write leaves stored contents untouched.

// File: rtl/sram_front_pkg.sv
package sram_front_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DROP = 2'd2
  } strobe_act_e;

  // Strobe decision: the processor strobe counts only with ce1 active and
  // takes precedence; an unmasked strobe with any enable off deselects.
  function automatic strobe_act_e decide_strobe(
    input logic adsp_n,
    input logic adsc_n,
    input logic ce1_n,
    input logic ce2,
    input logic ce3_n
  );
    logic cs_ok;
    logic proc_seen;
    logic seen;
    cs_ok     = !ce1_n && ce2 && !ce3_n;
    proc_seen = !adsp_n && !ce1_n;
    seen      = proc_seen || !adsc_n;
    if (!seen)      return ACT_IDLE;
    else if (cs_ok) return ACT_LOAD;
    else            return ACT_DROP;
  endfunction

endpackage

// File: rtl/sram_addr_ctl.sv
module sram_addr_ctl
  import sram_front_pkg::*;
#(
  parameter int AW    = 18,
  parameter int CNT_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  output logic          sel_q,
  output logic          cont,
  output logic [AW-1:0] eff_addr
);

  localparam int HI_W = AW - CNT_W;

  strobe_act_e          act;
  logic [HI_W-1:0]      hi_q;
  logic [CNT_W-1:0]     cnt_q;

  always_comb act = decide_strobe(adsp_n, adsc_n, ce1_n, ce2, ce3_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      hi_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          sel_q <= 1'b1;
          hi_q  <= addr[AW-1:CNT_W];
          cnt_q <= addr[CNT_W-1:0];
        end
        ACT_DROP: sel_q <= 1'b0;
        default: begin
          // counter wraps naturally inside the aligned block
          if (sel_q && !adv_n) cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign cont     = sel_q && (act == ACT_IDLE);
  assign eff_addr = {hi_q, cnt_q};

endmodule

// File: rtl/sram_lane_dec.sv
module sram_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             cont,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = cont && (!gw_n || (!bwe_n && !bw_n[g]));
  end

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int MEM_AW = 6,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [MEM_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rword
);

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) bank[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rword[g*LANE_W +: LANE_W] = bank[idx];
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [DW-1:0] rword,
  input  logic          oe_n,
  output logic          dq_oe,
  output logic [DW-1:0] rdata
);

  logic          live_q;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      hold_q <= '0;
    end else begin
      live_q <= rd_en;
      if (rd_en) hold_q <= rword;
    end
  end

  assign dq_oe = live_q && !oe_n;
  assign rdata = dq_oe ? hold_q : '0;

endmodule

// File: rtl/sram_burst_front.sv
module sram_burst_front #(
  parameter int AW     = 18,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int MEM_AW = 6,
  parameter int CNT_W  = 2,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  output logic [AW-1:0]    burst_addr,
  output logic [LANES-1:0] lane_we,
  output logic             dq_oe,
  output logic [DW-1:0]    rdata
);

  logic          sel_q;
  logic          cont;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] rword;
  logic          rd_en;

  sram_addr_ctl #(.AW(AW), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .sel_q(sel_q), .cont(cont), .eff_addr(eff_addr)
  );

  sram_lane_dec #(.LANES(LANES)) u_lane (
    .cont(cont), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .lane_we(lane_we)
  );

  sram_store #(.LANES(LANES), .LANE_W(LANE_W), .MEM_AW(MEM_AW)) u_store (
    .clk(clk), .we(lane_we), .idx(eff_addr[MEM_AW-1:0]),
    .wdata(wdata), .rword(rword)
  );

  // a selected edge reads unless it writes
  assign rd_en = sel_q && !(|lane_we);

  sram_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rword(rword),
    .oe_n(oe_n), .dq_oe(dq_oe), .rdata(rdata)
  );

  assign burst_addr = eff_addr;

endmodule

// File: rtl/sram_burst_front_chk.sv
module sram_burst_front_chk #(
  parameter int AW    = 18,
  parameter int LANES = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             adv_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             gw_n,
  input logic             oe_n,
  input logic [AW-1:0]    burst_addr,
  input logic [LANES-1:0] lane_we,
  input logic             dq_oe,
  input logic [DW-1:0]    rdata,
  input logic             sel
);

  logic cs_ok, seen;
  assign cs_ok = !ce1_n && ce2 && !ce3_n;
  assign seen  = (!adsp_n && !ce1_n) || !adsc_n;

  // R1
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && cs_ok |=> burst_addr == $past(addr));

  // R2
  deselect_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !cs_ok |-> lane_we == '0);

  // R3
  ce1_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adsp_n && ce1_n && adsc_n |=> burst_addr[AW-1:2] == $past(burst_addr[AW-1:2]));

  // R4
  strobe_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adsp_n && !adsc_n && !ce1_n |-> lane_we == '0);

  // R6
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !seen && !adv_n |=> burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1);

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen && (adv_n || !sel) |=> $stable(burst_addr));

  // R8
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !seen && !gw_n |-> lane_we == '1);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe && rdata == '0);

  // R12
  first_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel && seen && cs_ok |=> !dq_oe);

endmodule

bind sram_burst_front sram_burst_front_chk #(.AW(AW), .LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
  .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
  .oe_n(oe_n), .burst_addr(burst_addr), .lane_we(lane_we), .dq_oe(dq_oe),
  .rdata(rdata), .sel(sel_q)
);

// File: tb/sram_burst_front_bench.sv
module sram_burst_front_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic        ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic [31:0] wdata = '0;
  logic        oe_n = 1'b0;
  logic [17:0] burst_addr;
  logic [3:0]  lane_we;
  logic        dq_oe;
  logic [31:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_burst_front u_sram_burst_front (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n),
    .burst_addr(burst_addr), .lane_we(lane_we), .dq_oe(dq_oe), .rdata(rdata)
  );

  typedef struct packed {
    logic        adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
    logic [3:0]  bw_n;
    logic [17:0] addr;
    logic [31:0] wd;
    logic [3:0]  e_lane;
    logic [17:0] e_addr;
    logic        e_oe;
    logic [31:0] e_rd;
  } vec_t;

  // strobes/adv/enables, writes, addr, wdata | lane before edge, addr/oe/rdata after edge
  localparam vec_t VECS [20] = '{
    '{1,0,1,0,1,0, 0,1,4'hF, 18'h11, 32'h0,        4'h0, 18'h11, 0, 32'h0},        // R1 R4 capture, gw ignored
    '{1,1,0,0,1,0, 0,1,4'hF, 18'h0,  32'h11111111, 4'hF, 18'h12, 0, 32'h0},        // R8 R5 R12
    '{1,1,0,0,1,0, 0,1,4'hF, 18'h0,  32'h22222222, 4'hF, 18'h13, 0, 32'h0},
    '{1,1,0,0,1,0, 0,1,4'hF, 18'h0,  32'h33333333, 4'hF, 18'h10, 0, 32'h0},        // R6 wrap
    '{1,1,0,0,1,0, 0,1,4'hF, 18'h0,  32'h44444444, 4'hF, 18'h11, 0, 32'h0},
    '{1,1,1,0,1,0, 1,0,4'hA, 18'h0,  32'hAAAAAAAA, 4'h5, 18'h11, 0, 32'h0},        // R9 R7
    '{1,1,1,0,1,0, 1,1,4'h0, 18'h0,  32'h0,        4'h0, 18'h11, 1, 32'h11AA11AA}, // R9 R10
    '{0,1,1,0,1,0, 0,1,4'hF, 18'h12, 32'h0,        4'h0, 18'h12, 1, 32'h11AA11AA}, // R4 R10
    '{1,1,0,0,1,0, 1,1,4'hF, 18'h0,  32'h0,        4'h0, 18'h13, 1, 32'h22222222},
    '{1,1,0,0,1,0, 1,1,4'hF, 18'h0,  32'h0,        4'h0, 18'h10, 1, 32'h33333333},
    '{1,1,0,0,1,0, 1,1,4'hF, 18'h0,  32'h0,        4'h0, 18'h11, 1, 32'h44444444},
    '{0,1,0,1,1,0, 1,1,4'hF, 18'h30, 32'h0,        4'h0, 18'h12, 1, 32'h11AA11AA}, // R3
    '{1,0,1,0,0,0, 1,1,4'hF, 18'h30, 32'h0,        4'h0, 18'h12, 1, 32'h22222222}, // R2
    '{1,1,1,0,1,0, 0,1,4'hF, 18'h0,  32'h0,        4'h0, 18'h12, 0, 32'h0},        // R2 R5
    '{0,0,1,0,1,0, 0,1,4'hF, 18'h13, 32'h0,        4'h0, 18'h13, 0, 32'h0},        // R4 R12
    '{1,1,1,0,1,0, 1,1,4'hF, 18'h0,  32'h0,        4'h0, 18'h13, 1, 32'h33333333},
    '{0,0,1,1,1,0, 1,1,4'hF, 18'h05, 32'h0,        4'h0, 18'h13, 1, 32'h33333333}, // R4 R2
    '{1,1,1,0,1,0, 1,1,4'hF, 18'h0,  32'h0,        4'h0, 18'h13, 0, 32'h0},
    '{1,0,1,0,1,1, 1,1,4'hF, 18'h05, 32'h0,        4'h0, 18'h13, 0, 32'h0},        // R2
    '{1,1,0,0,1,0, 0,1,4'hF, 18'h0,  32'h0,        4'h0, 18'h13, 0, 32'h0}         // R7 R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    adsp_n = v.adsp_n; adsc_n = v.adsc_n; adv_n = v.adv_n;
    ce1_n = v.ce1_n; ce2 = v.ce2; ce3_n = v.ce3_n;
    gw_n = v.gw_n; bwe_n = v.bwe_n; bw_n = v.bw_n;
    addr = v.addr; wdata = v.wd;
  endtask

  task automatic idle_inputs();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; addr = '0; wdata = '0;
  endtask

  // drive at falling edge, then pass the next rising edge and settle
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    gw_n = 0;
    #1;
    // R13 reset state
    check("R13 dq_oe", {31'b0, dq_oe}, 32'h0);
    check("R13 burst_addr", {14'b0, burst_addr}, 32'h0);
    check("R13 lane_we", {28'b0, lane_we}, 32'h0);
    check("R13 rdata", rdata, 32'h0);
    rst_n = 1;
    gw_n = 1;

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #1;
      check($sformatf("R8 R9 lane row %0d", i), {28'b0, lane_we}, {28'b0, VECS[i].e_lane});
      tick();
      check($sformatf("R1 R6 addr row %0d", i), {14'b0, burst_addr}, {14'b0, VECS[i].e_addr});
      check($sformatf("R10 R12 oe row %0d", i), {31'b0, dq_oe}, {31'b0, VECS[i].e_oe});
      check($sformatf("R10 rdata row %0d", i), rdata, VECS[i].e_rd);
    end

    // R6 wrap with upper bits held
    @(negedge clk); idle_inputs(); adsc_n = 0; addr = 18'h20007;
    tick();
    check("R1 load high addr", {14'b0, burst_addr}, 32'h20007);
    @(negedge clk); idle_inputs(); adv_n = 0;
    tick();
    check("R6 wrap 3 to 0", {14'b0, burst_addr}, 32'h20004);
    @(negedge clk); idle_inputs(); adv_n = 0;
    tick();
    check("R6 step 0 to 1", {14'b0, burst_addr}, 32'h20005);

    // R11 asynchronous output gate
    @(negedge clk); idle_inputs(); adsc_n = 0; addr = 18'h10;
    tick();
    @(negedge clk); idle_inputs();
    tick();
    check("R10 read 0x10", rdata, 32'h44444444);
    #3 oe_n = 1;
    #1;
    check("R11 oe high dq_oe", {31'b0, dq_oe}, 32'h0);
    check("R11 oe high rdata", rdata, 32'h0);
    #1 oe_n = 0;
    #1;
    check("R11 oe low again", rdata, 32'h44444444);

    // R13 reset mid-burst
    @(negedge clk); rst_n = 0;
    #1;
    check("R13 reset dq_oe", {31'b0, dq_oe}, 32'h0);
    check("R13 reset addr", {14'b0, burst_addr}, 32'h0);
    @(negedge clk); rst_n = 1; gw_n = 0;
    #1;
    check("R13 deselected no write", {28'b0, lane_we}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule